// File: doc/BRIEF.md
# Response Buffer Map Allocator

The block owns the assignment map for sixteen read-response buffers. The map is split into two 32-bit banks. One bank serves even-numbered slots and the other serves odd-numbered slots. Each bank packs eight 4-bit descriptors. Each descriptor says whether its buffer is enabled and, if it is, which virtual channel and device own it.

A command names an operation, a slot, a virtual channel and a quantity. There are four operations:
- count the buffers owned by a slot/channel pair;
- count the free buffers in the slot's bank;
- allocate up to the quantity;
- free up to the quantity.

The block walks the eight descriptors of the selected bank from the lowest field to the highest, one field per clock. It writes the bank back once at the end of the walk. It then reports the number of buffers counted or changed, and a shortfall flag. After a free, it also reports which fields were released, both as a field mask and as global buffer numbers. A separate drain sequencer consumes those buffer numbers.

Top module: `rsp_buf_map`

## Requirements
- R1: Descriptor field i occupies bank bits [4i+3:4i]. Bit 3 is enable, bits 2..1 are the virtual channel and bit 0 is slot bit 1. Slot bit 0 selects the bank (0 = even, 1 = odd). Both banks read as 0 after reset and are visible on map_even_o and map_odd_o.
- R2: A command whose slot exceeds 3 or whose channel exceeds 3 is rejected. reject_o pulses high in the next cycle, busy_o stays low, done_o does not pulse, and neither bank changes.
- R3: Count-valid (op 0) reports how many fields of the selected bank equal the full 4-bit code {1, channel, slot[1]}.
- R4: Count-free (op 1) reports how many fields of the selected bank have the enable bit clear, whatever their other bits hold.
- R5: Allocate (op 2) visits fields 0 to 7 in order. It overwrites each field whose enable bit is clear with the command's code, and stops changing fields once the quantity has been placed.
- R6: Free (op 3) visits fields 0 to 7 in order. It clears only the enable bit of each field that equals the command's code and leaves bits 2..0 as they were. It stops once the quantity has been released.
- R7: If allocate or free cannot reach its quantity, every change it made is kept, result_cnt_o gives the number actually changed, and short_o is high in the done cycle. Count operations and quantity-zero requests never raise short_o.
- R8: After a free, freed_mask_o bit i is set for each released field. freed_bufs_o bit (2*i + slot[0]) is set for the same fields, and all other bits of freed_bufs_o are clear.
- R9: A command is accepted only while busy_o is low. busy_o is then high for exactly 8 cycles, and done_o pulses for one cycle right after. The bank changes only in the cycle done_o rises. Commands presented while busy_o is high are ignored.
- R10: During reset, busy_o, done_o, reject_o, short_o and result_cnt_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, sampled while idle |
| cmd_op_i | input | 2 | 0 count-valid, 1 count-free, 2 allocate, 3 free |
| cmd_slot_i | input | 3 | Slot number, 0..3 legal |
| cmd_vc_i | input | 3 | Virtual channel, 0..3 legal |
| cmd_qty_i | input | 4 | Quantity for allocate or free |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | One-cycle pulse for an out-of-range command |
| short_o | output | 1 | Allocate or free fell short, valid with done_o |
| result_cnt_o | output | 4 | Fields counted or changed by the last command |
| freed_mask_o | output | 8 | Fields released by the last free |
| freed_bufs_o | output | 16 | Global numbers of the released buffers |
| map_even_o | output | 32 | Even-slot bank |
| map_odd_o | output | 32 | Odd-slot bank |

## Verification
The bench goes after these corner cases:
- A free must leave channel and device bits behind. A design that cleared the whole field would produce a bank of zeros where stale codes are expected.
- Allocation into a fragmented bank must fill the lowest holes first. An order error shows up as codes in the wrong nibbles.
- Requests larger than what is free or owned must stop partway and raise the shortfall flag. A design that rolled back, or that kept writing past the quantity, reports a wrong count or a wrong bank.
- Out-of-range slots and channels, and commands issued during a scan, must leave the banks and the scan length untouched.
- Released fields must map to global buffer numbers in the interleaved even/odd order, so a swapped bank bit is caught on the odd-slot frees.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int RBM_FLD_W   = 4;
  localparam int RBM_NUM_FLD = 8;

  typedef enum logic [1:0] {
    OP_CNT_VALID = 2'd0,
    OP_CNT_FREE  = 2'd1,
    OP_ALLOC     = 2'd2,
    OP_FREE      = 2'd3
  } rbm_op_e;

  function automatic logic op_changes(rbm_op_e op);
    return (op == OP_ALLOC) || (op == OP_FREE);
  endfunction
endpackage

// File: rtl/rbm_field_eval.sv
module rbm_field_eval
  import rbm_pkg::*;
#(
  parameter int FLD_W = RBM_FLD_W
) (
  input  rbm_op_e          op_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic [FLD_W-1:0] code_i,
  input  logic             room_i,
  output logic             hit_o,
  output logic [FLD_W-1:0] fld_o
);
  localparam logic [FLD_W-1:0] EN_BIT = FLD_W'(1) << (FLD_W - 1);

  logic en, match;
  assign en    = fld_i[FLD_W-1];
  assign match = (fld_i == code_i);

  always_comb begin
    hit_o = 1'b0;
    fld_o = fld_i;
    unique case (op_i)
      OP_CNT_VALID: hit_o = match;
      OP_CNT_FREE:  hit_o = !en;
      OP_ALLOC: begin
        hit_o = !en && room_i;
        if (hit_o) fld_o = code_i;
      end
      OP_FREE: begin
        hit_o = match && room_i;
        // only the enable bit is dropped
        if (hit_o) fld_o = fld_i & ~EN_BIT;
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbm_scan_ctrl.sv
module rbm_scan_ctrl #(
  parameter  int NUM_FLD = 8,
  localparam int IDX_W   = $clog2(NUM_FLD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign last_o = busy_q && (idx_q == IDX_W'(NUM_FLD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  // R9
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> busy_o && (idx_o == IDX_W'($past(idx_o) + 1'b1)));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  start_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && (idx_o == '0));
  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));
endmodule

// File: rtl/rsp_buf_map.sv
module rsp_buf_map
  import rbm_pkg::*;
#(
  parameter  int FLD_W    = RBM_FLD_W,
  parameter  int NUM_FLD  = RBM_NUM_FLD,
  parameter  int SLOT_W   = 3,
  parameter  int VC_W     = 3,
  parameter  int QTY_W    = 4,
  parameter  int MAX_SLOT = 3,
  parameter  int MAX_VC   = 3,
  localparam int REG_W    = FLD_W * NUM_FLD,
  localparam int IDX_W    = $clog2(NUM_FLD),
  localparam int CNT_W    = $clog2(NUM_FLD + 1),
  localparam int NBUF     = 2 * NUM_FLD,
  localparam int VCB      = FLD_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [SLOT_W-1:0] cmd_slot_i,
  input  logic [VC_W-1:0]   cmd_vc_i,
  input  logic [QTY_W-1:0]  cmd_qty_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o,
  output logic              short_o,
  output logic [CNT_W-1:0]  result_cnt_o,
  output logic [NUM_FLD-1:0] freed_mask_o,
  output logic [NBUF-1:0]   freed_bufs_o,
  output logic [REG_W-1:0]  map_even_o,
  output logic [REG_W-1:0]  map_odd_o
);
  localparam logic [REG_W-1:0] KEEP_MASK = {NUM_FLD{{1'b0, {(FLD_W-1){1'b1}}}}};

  logic [REG_W-1:0]  map_q [2];
  rbm_op_e           op_q;
  logic [SLOT_W-1:0] slot_q;
  logic [VC_W-1:0]   vc_q;
  logic [QTY_W-1:0]  qty_q, rem_q, rem_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [NUM_FLD-1:0] mask_q;
  logic [REG_W-1:0]  work_q, work_nxt;
  logic              short_q, rej_q;

  logic             cmd_ok, start, busy, last, step;
  logic [IDX_W-1:0] idx;
  logic [FLD_W-1:0] code, cur_fld, new_fld;
  logic             hit, chg;

  assign cmd_ok = (cmd_slot_i <= SLOT_W'(MAX_SLOT)) && (cmd_vc_i <= VC_W'(MAX_VC));
  assign start  = cmd_valid_i && !busy && cmd_ok;
  assign step   = busy;

  rbm_scan_ctrl #(.NUM_FLD(NUM_FLD)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .last_o  (last),
    .idx_o   (idx),
    .done_o  (done_o)
  );

  assign code    = {1'b1, vc_q[VCB-1:0], slot_q[1]};
  assign cur_fld = work_q[idx*FLD_W +: FLD_W];
  assign chg     = op_changes(op_q);

  rbm_field_eval #(.FLD_W(FLD_W)) i_eval (
    .op_i   (op_q),
    .fld_i  (cur_fld),
    .code_i (code),
    .room_i (rem_q != '0),
    .hit_o  (hit),
    .fld_o  (new_fld)
  );

  always_comb begin
    work_nxt = work_q;
    work_nxt[idx*FLD_W +: FLD_W] = new_fld;
  end

  assign rem_nxt = (hit && chg) ? rem_q - 1'b1 : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_CNT_VALID;
      slot_q  <= '0;
      vc_q    <= '0;
      qty_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      work_q  <= '0;
      short_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= cmd_valid_i && !busy && !cmd_ok;
      if (start) begin
        op_q    <= rbm_op_e'(cmd_op_i);
        slot_q  <= cmd_slot_i;
        vc_q    <= cmd_vc_i;
        qty_q   <= cmd_qty_i;
        rem_q   <= cmd_qty_i;
        cnt_q   <= '0;
        mask_q  <= '0;
        work_q  <= cmd_slot_i[0] ? map_q[1] : map_q[0];
        short_q <= 1'b0;
      end else if (step) begin
        work_q <= work_nxt;
        rem_q  <= rem_nxt;
        if (hit) cnt_q <= cnt_q + 1'b1;
        if (hit && chg) mask_q[idx] <= 1'b1;
        short_q <= last && chg && (rem_nxt != '0);
      end else begin
        short_q <= 1'b0;
      end
    end
  end

  // bank write-back, once per scan
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         map_q[b] <= '0;
      else if (last && (slot_q[0] == b[0])) map_q[b] <= work_nxt;
    end
  end

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_bufnum
    assign freed_bufs_o[2*i]   = mask_q[i] && !slot_q[0] && (op_q == OP_FREE);
    assign freed_bufs_o[2*i+1] = mask_q[i] &&  slot_q[0] && (op_q == OP_FREE);
  end

  assign busy_o       = busy;
  assign reject_o     = rej_q;
  assign short_o      = short_q;
  assign result_cnt_o = cnt_q;
  assign freed_mask_o = (op_q == OP_FREE) ? mask_q : '0;
  assign map_even_o   = map_q[0];
  assign map_odd_o    = map_q[1];

  // R9
  map_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(map_q[0]) && $stable(map_q[1]));
  // R2
  reject_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !busy_o && !done_o && $stable(map_q[0]) && $stable(map_q[1]));
  // R7
  short_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> done_o && op_changes(op_q));
  // R5
  qty_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_changes(op_q) |-> (QTY_W'(result_cnt_o) <= qty_q));
  // R8
  mask_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q == OP_FREE) |-> ($countones(freed_mask_o) == int'(result_cnt_o)));
  // R6
  free_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q == OP_FREE) |->
      ((map_q[slot_q[0]] & KEEP_MASK) == ($past(map_q[slot_q[0]]) & KEEP_MASK)));
  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !done_o && !reject_o && !short_o);
endmodule

// File: tb/test_rsp_buf_map.sv
module test_rsp_buf_map;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_slot = '0;
  logic [2:0]  cmd_vc = '0;
  logic [3:0]  cmd_qty = '0;
  logic        busy_o, done_o, reject_o, short_o;
  logic [3:0]  result_cnt_o;
  logic [7:0]  freed_mask_o;
  logic [15:0] freed_bufs_o;
  logic [31:0] map_even_o, map_odd_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_even = '0, m_odd = '0;

  always #5 clk = ~clk;

  rsp_buf_map i_rsp_buf_map (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_slot_i(cmd_slot), .cmd_vc_i(cmd_vc), .cmd_qty_i(cmd_qty),
    .busy_o(busy_o), .done_o(done_o), .reject_o(reject_o), .short_o(short_o),
    .result_cnt_o(result_cnt_o), .freed_mask_o(freed_mask_o),
    .freed_bufs_o(freed_bufs_o), .map_even_o(map_even_o), .map_odd_o(map_odd_o));

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: R1, R3..R8
  task automatic model(input int op, input int slot, input int vc, input int qty,
                       output int cnt, output bit sh, output logic [7:0] msk);
    logic [31:0] r;
    logic [3:0]  code, f;
    int rem;
    r = slot[0] ? m_odd : m_even;
    code = {1'b1, vc[1:0], slot[1]};
    rem = qty; cnt = 0; msk = '0;
    for (int i = 0; i < 8; i++) begin
      f = r[4*i +: 4];
      case (op)
        0: if (f == code) cnt++;
        1: if (!f[3]) cnt++;
        2: if (!f[3] && rem > 0) begin r[4*i +: 4] = code; rem--; cnt++; end
        default: if (f == code && rem > 0) begin r[4*i +: 4] = f & 4'h7; rem--; cnt++; msk[i] = 1'b1; end
      endcase
    end
    sh = (op >= 2) && (rem > 0);
    if (slot[0]) m_odd = r; else m_even = r;
  endtask

  function automatic logic [15:0] bufs(logic [7:0] msk, int slot, int op);
    logic [15:0] b = '0;
    if (op == 3) for (int i = 0; i < 8; i++) b[2*i + slot[0]] = msk[i];
    return b;
  endfunction

  task automatic run(input int op, input int slot, input int vc, input int qty,
                     input bit poke = 1'b0);
    int cnt, n; bit sh; logic [7:0] msk; bit bad;
    logic [31:0] pe, po;
    bad = (slot > 3) || (vc > 3);
    pe = m_even; po = m_odd;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_slot = slot[2:0]; cmd_vc = vc[2:0]; cmd_qty = qty[3:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    if (bad) begin
      check(reject_o && !busy_o, "R2 reject pulse", {busy_o, reject_o}, 32'h1);
      @(negedge clk);
      check(!reject_o && !done_o && map_even_o == pe && map_odd_o == po, "R2 banks unchanged",
            map_even_o ^ map_odd_o, pe ^ po);
      return;
    end
    model(op, slot, vc, qty, cnt, sh, msk);
    n = 0;
    while (busy_o && n < 20) begin
      n++;
      // R9: a command during the scan must be ignored
      if (poke && n == 3) begin cmd_valid = 1'b1; cmd_op = 2'd2; cmd_slot = 3'd0; cmd_qty = 4'd8; end
      else cmd_valid = 1'b0;
      if (n < 8) check(map_even_o == pe && map_odd_o == po, "R9 bank held during scan", map_even_o, pe);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(n == 8 && done_o, "R9 busy length and done", n, 8);
    check(int'(result_cnt_o) == cnt, "R3 R4 R5 R6 result count", result_cnt_o, cnt);
    check(short_o == sh, "R7 shortfall flag", short_o, sh);
    check(map_even_o == m_even && map_odd_o == m_odd, "R1 R5 R6 bank contents",
          slot[0] ? map_odd_o : map_even_o, slot[0] ? m_odd : m_even);
    if (op == 3) begin
      check(freed_mask_o == msk, "R8 freed mask", freed_mask_o, msk);
      check(freed_bufs_o == bufs(msk, slot, op), "R8 buffer numbers", freed_bufs_o, bufs(msk, slot, op));
    end
    @(negedge clk);
    check(!done_o && !short_o, "R9 done single pulse", {done_o, short_o}, 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    // R10
    check(!busy_o && !done_o && !reject_o && !short_o && result_cnt_o == 0, "R10 reset outputs",
          {busy_o, done_o, reject_o, short_o, result_cnt_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check(map_even_o == 0 && map_odd_o == 0, "R1 banks clear after reset", map_even_o | map_odd_o, 0);

    run(1, 0, 0, 0);                       // R4 all free
    run(2, 0, 1, 3);                       // R5 slot0 vc1 -> code A
    check(map_even_o == 32'h0000_0AAA, "R1 R5 code placement", map_even_o, 32'h0000_0AAA);
    run(2, 2, 0, 2);                       // R1 device bit from slot[1] -> code 9
    check(map_even_o == 32'h0009_9AAA, "R1 device bit", map_even_o, 32'h0009_9AAA);
    run(2, 1, 3, 1, 1'b1);                 // R1 odd bank, R9 poke ignored
    check(map_odd_o == 32'h0000_000E && map_even_o == 32'h0009_9AAA, "R9 busy command ignored",
          map_odd_o, 32'h0000_000E);
    run(0, 0, 1, 0);                       // R3 -> 3
    run(1, 2, 3, 0);                       // R4 -> 3
    run(3, 0, 1, 2);                       // R6 free keeps low bits
    check(map_even_o == 32'h0009_9A22, "R6 only enable cleared", map_even_o, 32'h0009_9A22);
    check(freed_bufs_o == 16'h0005, "R8 even buffer numbers", freed_bufs_o, 16'h0005);
    run(2, 0, 2, 5);                       // R5 fills holes low to high
    check(map_even_o == 32'hCCC9_9ACC, "R5 low-first fill", map_even_o, 32'hCCC9_9ACC);
    run(2, 0, 2, 1);                       // R7 no room
    run(3, 2, 0, 4);                       // R7 partial free
    check(map_even_o == 32'hCCC1_1ACC, "R7 partial kept", map_even_o, 32'hCCC1_1ACC);
    run(3, 1, 3, 1);                       // R8 odd bank numbering
    run(2, 3, 0, 0);                       // R7 quantity zero
    run(0, 4, 0, 1);                       // R2 bad slot
    run(2, 1, 5, 2);                       // R2 bad channel
    for (int k = 0; k < 300; k++) begin
      int op, sl, vc, q;
      op = int'($urandom_range(0, 3));
      sl = int'($urandom_range(0, 9)) > 8 ? 4 + int'($urandom_range(0, 3)) : int'($urandom_range(0, 3));
      vc = int'($urandom_range(0, 19)) == 0 ? 4 + int'($urandom_range(0, 3)) : int'($urandom_range(0, 3));
      q  = int'($urandom_range(0, 10));
      run(op, sl, vc, q, k[4]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule